// File: doc/BRIEF.md
# VME Bus Master Transfer Sequencer

This block runs the master side of VME data transfers in 24-bit address space. A client presents an address, up to 64 bits of write data, a 6-bit address-modifier code and a read/write flag, then pulses a go line. The sequencer decodes the modifier to choose a single-cycle, block (32-bit beats) or multiplexed 64-bit block transfer. It drives the address strobe, the two data strobes, the address and data groups and their direction controls, and it waits on the slave's acknowledge. Read data comes back with a data-present flag. Block transfers stop after every beat until the client decides whether to go on.

Each strobe is preceded by a fixed data-to-strobe setup count. A watchdog closes any transfer whose acknowledge never arrives. In the 64-bit block mode, the address group is released once the addressing beat is acknowledged. On later beats the address lines carry the upper data half.

Top module: `vme_xfer_seq`

## Requirements
- R1: `reqGo` is a one-cycle pulse sampled while not busy. For a supported modifier, on the next cycle `rspBusy` is 1 and `rspGoTaken` is 1 for that single cycle. The address group drives `reqAddr`, the control group is driven, and `busIackN` is 1. For a write, the data group drives the low 32 bits of `reqWdata`. For a read, the data group stays an input.
- R2: `busAsN` is 0 from the first busy cycle. `busDsN` stays 2'b11 for SETUP_CYC (4) cycles after the data are placed, and then becomes 2'b00.
- R3: In a single-cycle write, the cycle after `busDtackN` is sampled 0 during the strobe, the block is idle. All three groups are released and `busAsN` is 1.
- R4: In a read, `rspDataValid` is 0 until the acknowledge. In the cycle after `busDtackN` is sampled 0, `rspDataValid` is 1 and `busDsN` is 2'b11. `rspRdata` then holds the sampled lines: {32'h0, data lines} for modifiers 0x39 and 0x3B, and {address lines, data lines} for 0x38.
- R5: After a single-cycle read, the block stays busy until `dataTaken` is sampled 1. The next cycle it is idle with `rspDataValid` at 0.
- R6: With modifier 0x38, the address group is driven during the addressing beat. From the cycle after that beat's acknowledge, `busAddrOe` is 0, and it stays 0 for the whole of every read data beat.
- R7: In a block transfer (0x3B or 0x38 data beat), the acknowledge raises `busDsN` to 2'b11 and `rspBlkAsk` to 1. `rspBlkAsk` stays 1 until `blkDecided` is sampled 1. With `blkContinue` at 0, the block is then idle.
- R8: When `blkDecided` and `blkContinue` are both sampled 1, the next `reqAddr` and `reqWdata` appear on the bus the following cycle, and `busDsN` holds 2'b11 while `busDtackN` stays 0. After `busDtackN` is sampled 1, `busDsN` goes to 2'b00 SETUP_CYC cycles later.
- R9: `rspErr` reads 0 after a request with modifier 0x39, 0x3B or 0x38. After any other code it reads 1, `rspBusy` stays 0 and `busAsN` stays 1.
- R10: If no acknowledge edge arrives within WDOG_CYC cycles of waiting, the block goes idle, releases every group and sets `rspErr` to 2.
- R11: Whenever the block is idle, the address, data and control groups are all inputs and `busAsN` is 1. Reset leaves the block idle with `rspErr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqGo | input | 1 | One-cycle request pulse |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAm | input | 6 | Address-modifier code |
| reqAddr | input | ADDR_W | Transfer address |
| reqWdata | input | 2*ADDR_W | Write data |
| rspBusy | output | 1 | Transfer in progress |
| rspGoTaken | output | 1 | Request latched (one cycle) |
| rspDataValid | output | 1 | Read data present |
| rspRdata | output | 2*ADDR_W | Captured read data |
| rspErr | output | 2 | 0 ok, 1 bad modifier, 2 timeout |
| dataTaken | input | 1 | Client consumed single-cycle read data |
| rspBlkAsk | output | 1 | Block beat done, awaiting decision |
| blkDecided | input | 1 | Client decision valid |
| blkContinue | input | 1 | 1 = run another beat |
| busAddrOut | output | ADDR_W | Address group value |
| busAddrIn | input | ADDR_W | Address group sampled value |
| busAddrOe | output | 1 | Address group drive enable |
| busDataOut | output | ADDR_W | Data group value |
| busDataIn | input | ADDR_W | Data group sampled value |
| busDataOe | output | 1 | Data group drive enable |
| busAsN | output | 1 | Address strobe, active low |
| busDsN | output | 2 | Data strobes, active low |
| busIackN | output | 1 | Interrupt acknowledge line, held inactive |
| busCtrlOe | output | 1 | Strobe/IACK group drive enable |
| busDtackN | input | 1 | Slave acknowledge, active low |

## Verification
The bench counts the setup gap exactly, both on the first beat and after a block-transfer restart. A sequencer that counts the wait from the wrong event would strobe one cycle early or late. The addressing beat of the 64-bit mode is checked with the address drive enable observed. A design that kept driving there would contend with the slave's upper data half, and a wrong merge would show up as swapped or zeroed halves in the scoreboard. A rejected modifier must leave the strobe and busy lines untouched, which a design that started the cycle first would violate. The watchdog is checked to the exact cycle, with the release and error code observed together.

// File: rtl/vme_seq_pkg.sv
package vme_seq_pkg;

  localparam int AM_W = 6;

  localparam logic [AM_W-1:0] AM_STD_DATA = 6'h39;
  localparam logic [AM_W-1:0] AM_STD_BLT  = 6'h3B;
  localparam logic [AM_W-1:0] AM_STD_MBLT = 6'h38;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_BADAM   = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;

  typedef enum logic [1:0] {XF_SINGLE, XF_BLT, XF_MBLT, XF_BAD} xferKind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_RDHOLD, ST_DECIDE, ST_WAITREL
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadNext;
    logic capture;
    logic clrValid;
    logic timeout;
    logic addrDone;
    logic cntClr;
    logic cntInc;
  } ctlStrobe_t;

  function automatic xferKind_e decodeAm(input logic [AM_W-1:0] am);
    case (am)
      AM_STD_DATA: return XF_SINGLE;
      AM_STD_BLT:  return XF_BLT;
      AM_STD_MBLT: return XF_MBLT;
      default:     return XF_BAD;
    endcase
  endfunction

endpackage

// File: rtl/vme_seq_dpath.sv
module vme_seq_dpath
  import vme_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            ctl,
  input  seqState_e             state,
  input  logic [AM_W-1:0]       reqAm,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2*ADDR_W-1:0]   reqWdata,
  input  logic [ADDR_W-1:0]     busAddrIn,
  input  logic [ADDR_W-1:0]     busDataIn,
  output xferKind_e             kindNow,
  output xferKind_e             kindQ,
  output logic                  writeQ,
  output logic                  addrPhaseQ,
  output logic [CNT_W-1:0]      cnt,
  output logic                  rspGoTaken,
  output logic                  rspDataValid,
  output logic [2*ADDR_W-1:0]   rspRdata,
  output logic [1:0]            rspErr,
  output logic [ADDR_W-1:0]     busAddrOut,
  output logic                  busAddrOe,
  output logic [ADDR_W-1:0]     busDataOut,
  output logic                  busDataOe,
  output logic                  busAsN,
  output logic [1:0]            busDsN,
  output logic                  busIackN,
  output logic                  busCtrlOe
);

  localparam int DATA_W = 2 * ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              validQ;
  logic [1:0]        errQ;
  logic              goTakenQ;

  assign kindNow = decodeAm(reqAm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      wdataQ     <= '0;
      writeQ     <= 1'b0;
      kindQ      <= XF_SINGLE;
      addrPhaseQ <= 1'b0;
      errQ       <= ERR_NONE;
      goTakenQ   <= 1'b0;
    end else begin
      goTakenQ <= ctl.loadReq;
      if (ctl.loadReq) begin
        addrQ      <= reqAddr;
        wdataQ     <= reqWdata;
        writeQ     <= reqWrite;
        kindQ      <= kindNow;
        addrPhaseQ <= (kindNow == XF_MBLT);
        errQ       <= (kindNow == XF_BAD) ? ERR_BADAM : ERR_NONE;
      end else if (ctl.loadNext) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.addrDone) addrPhaseQ <= 1'b0;
      if (ctl.timeout)  errQ       <= ERR_TIMEOUT;
    end
  end

  // Read capture and data-present flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      validQ <= 1'b0;
    end else if (ctl.capture) begin
      rdataQ <= (kindQ == XF_MBLT) ? {busAddrIn, busDataIn}
                                   : {{ADDR_W{1'b0}}, busDataIn};
      validQ <= 1'b1;
    end else if (ctl.clrValid) begin
      validQ <= 1'b0;
    end
  end

  // Shared setup / watchdog counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.cntClr)  cnt <= '0;
    else if (ctl.cntInc)  cnt <= cnt + 1'b1;
  end

  logic active;
  logic mblt;
  logic beatPhase;

  always_comb begin
    active    = (state != ST_IDLE);
    mblt      = (kindQ == XF_MBLT);
    beatPhase = (state == ST_SETUP) || (state == ST_STROBE);

    busCtrlOe  = active;
    busAsN     = !active;
    busIackN   = 1'b1;
    busDsN     = (state == ST_STROBE) ? 2'b00 : 2'b11;
    busAddrOe  = active && (!mblt || addrPhaseQ || (writeQ && beatPhase));
    busAddrOut = (mblt && !addrPhaseQ) ? wdataQ[DATA_W-1:ADDR_W] : addrQ;
    busDataOe  = active && writeQ && !(mblt && addrPhaseQ);
    busDataOut = wdataQ[ADDR_W-1:0];
  end

  assign rspGoTaken   = goTakenQ;
  assign rspDataValid = validQ;
  assign rspRdata     = rdataQ;
  assign rspErr       = errQ;

endmodule

// File: rtl/vme_seq_ctrl.sv
module vme_seq_ctrl
  import vme_seq_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int WDOG_CYC  = 256,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqGo,
  input  xferKind_e        kindNow,
  input  xferKind_e        kindQ,
  input  logic             writeQ,
  input  logic             addrPhaseQ,
  input  logic [CNT_W-1:0] cnt,
  input  logic             busDtackN,
  input  logic             blkDecided,
  input  logic             blkContinue,
  input  logic             dataTaken,
  output seqState_e        state,
  output ctlStrobe_t       ctl,
  output logic             rspBusy,
  output logic             rspBlkAsk
);

  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WDOG_LAST  = CNT_W'(WDOG_CYC - 1);

  seqState_e nxt;

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (reqGo) begin
          ctl.loadReq = 1'b1;
          if (kindNow != XF_BAD) begin
            ctl.cntClr = 1'b1;
            nxt        = ST_SETUP;
          end
        end
      end
      ST_SETUP: begin
        if (cnt == SETUP_LAST) begin
          ctl.cntClr = 1'b1;
          nxt        = ST_STROBE;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_STROBE: begin
        if (!busDtackN) begin
          ctl.cntClr = 1'b1;
          if (addrPhaseQ) begin
            ctl.addrDone = 1'b1;
            nxt          = ST_WAITREL;
          end else begin
            ctl.capture = !writeQ;
            if (kindQ == XF_SINGLE) nxt = writeQ ? ST_IDLE : ST_RDHOLD;
            else                    nxt = ST_DECIDE;
          end
        end else if (cnt == WDOG_LAST) begin
          ctl.timeout = 1'b1;
          nxt         = ST_IDLE;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      ST_RDHOLD: begin
        if (dataTaken) begin
          ctl.clrValid = 1'b1;
          nxt          = ST_IDLE;
        end
      end
      ST_DECIDE: begin
        if (blkDecided) begin
          ctl.clrValid = 1'b1;
          if (blkContinue) begin
            ctl.loadNext = 1'b1;
            ctl.cntClr   = 1'b1;
            nxt          = ST_WAITREL;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_WAITREL: begin
        if (busDtackN) begin
          ctl.cntClr = 1'b1;
          nxt        = ST_SETUP;
        end else if (cnt == WDOG_LAST) begin
          ctl.timeout = 1'b1;
          nxt         = ST_IDLE;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign rspBusy   = (state != ST_IDLE);
  assign rspBlkAsk = (state == ST_DECIDE);

endmodule

// File: rtl/vme_xfer_seq.sv
module vme_xfer_seq
  import vme_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SETUP_CYC = 4,
  parameter int WDOG_CYC  = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqGo,
  input  logic                reqWrite,
  input  logic [5:0]          reqAm,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [2*ADDR_W-1:0] reqWdata,
  output logic                rspBusy,
  output logic                rspGoTaken,
  output logic                rspDataValid,
  output logic [2*ADDR_W-1:0] rspRdata,
  output logic [1:0]          rspErr,
  input  logic                dataTaken,
  output logic                rspBlkAsk,
  input  logic                blkDecided,
  input  logic                blkContinue,
  output logic [ADDR_W-1:0]   busAddrOut,
  input  logic [ADDR_W-1:0]   busAddrIn,
  output logic                busAddrOe,
  output logic [ADDR_W-1:0]   busDataOut,
  input  logic [ADDR_W-1:0]   busDataIn,
  output logic                busDataOe,
  output logic                busAsN,
  output logic [1:0]          busDsN,
  output logic                busIackN,
  output logic                busCtrlOe,
  input  logic                busDtackN
);

  localparam int CNT_MAX = (WDOG_CYC > SETUP_CYC) ? WDOG_CYC : SETUP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctlStrobe_t       ctl;
  seqState_e        state;
  xferKind_e        kindNow;
  xferKind_e        kindQ;
  logic             writeQ;
  logic             addrPhaseQ;
  logic [CNT_W-1:0] cnt;

  vme_seq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .WDOG_CYC  (WDOG_CYC),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqGo       (reqGo),
    .kindNow     (kindNow),
    .kindQ       (kindQ),
    .writeQ      (writeQ),
    .addrPhaseQ  (addrPhaseQ),
    .cnt         (cnt),
    .busDtackN   (busDtackN),
    .blkDecided  (blkDecided),
    .blkContinue (blkContinue),
    .dataTaken   (dataTaken),
    .state       (state),
    .ctl         (ctl),
    .rspBusy     (rspBusy),
    .rspBlkAsk   (rspBlkAsk)
  );

  vme_seq_dpath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .state        (state),
    .reqAm        (reqAm),
    .reqWrite     (reqWrite),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .busAddrIn    (busAddrIn),
    .busDataIn    (busDataIn),
    .kindNow      (kindNow),
    .kindQ        (kindQ),
    .writeQ       (writeQ),
    .addrPhaseQ   (addrPhaseQ),
    .cnt          (cnt),
    .rspGoTaken   (rspGoTaken),
    .rspDataValid (rspDataValid),
    .rspRdata     (rspRdata),
    .rspErr       (rspErr),
    .busAddrOut   (busAddrOut),
    .busAddrOe    (busAddrOe),
    .busDataOut   (busDataOut),
    .busDataOe    (busDataOe),
    .busAsN       (busAsN),
    .busDsN       (busDsN),
    .busIackN     (busIackN),
    .busCtrlOe    (busCtrlOe)
  );

endmodule

// File: rtl/vme_xfer_seq_chk.sv
module vme_xfer_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rspBusy,
  input logic       rspGoTaken,
  input logic       rspDataValid,
  input logic [1:0] rspErr,
  input logic       busAddrOe,
  input logic       busDataOe,
  input logic       busCtrlOe,
  input logic       busAsN,
  input logic [1:0] busDsN,
  input logic       busDtackN
);

  // R1
  go_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspGoTaken |=> !rspGoTaken);

  // R2
  ds_under_as_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busDsN != 2'b11) |-> !busAsN);

  // R2
  ds_after_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busDsN[0]) |-> $past(!busAsN, 3));

  // R4
  capture_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspDataValid) |-> $past(!busDtackN));

  // R9
  bad_am_no_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspGoTaken && rspErr == 2'd1) |-> (!rspBusy && busAsN));

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspBusy |-> (!busAddrOe && !busDataOe && !busCtrlOe && busAsN));

endmodule

bind vme_xfer_seq vme_xfer_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rspBusy      (rspBusy),
  .rspGoTaken   (rspGoTaken),
  .rspDataValid (rspDataValid),
  .rspErr       (rspErr),
  .busAddrOe    (busAddrOe),
  .busDataOe    (busDataOe),
  .busCtrlOe    (busCtrlOe),
  .busAsN       (busAsN),
  .busDsN       (busDsN),
  .busDtackN    (busDtackN)
);

// File: tb/test_vme_xfer_seq.sv
module test_vme_xfer_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int WDOG       = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqGo = 1'b0;
  logic          reqWrite = 1'b0;
  logic [5:0]    reqAm = 6'h00;
  logic [AW-1:0] reqAddr = '0;
  logic [2*AW-1:0] reqWdata = '0;
  logic          dataTaken = 1'b0;
  logic          blkDecided = 1'b0;
  logic          blkContinue = 1'b0;
  logic [AW-1:0] busAddrIn = '0;
  logic [AW-1:0] busDataIn = '0;
  logic          busDtackN = 1'b1;

  logic          rspBusy, rspGoTaken, rspDataValid, rspBlkAsk;
  logic [2*AW-1:0] rspRdata;
  logic [1:0]    rspErr;
  logic [AW-1:0] busAddrOut, busDataOut;
  logic          busAddrOe, busDataOe, busAsN, busIackN, busCtrlOe;
  logic [1:0]    busDsN;

  always #(CLK_PERIOD/2) clk = ~clk;

  vme_xfer_seq #(.ADDR_W(AW), .SETUP_CYC(4), .WDOG_CYC(WDOG)) i_vme_xfer_seq (
    .clk(clk), .rstN(rstN), .reqGo(reqGo), .reqWrite(reqWrite), .reqAm(reqAm),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspBusy(rspBusy),
    .rspGoTaken(rspGoTaken), .rspDataValid(rspDataValid), .rspRdata(rspRdata),
    .rspErr(rspErr), .dataTaken(dataTaken), .rspBlkAsk(rspBlkAsk),
    .blkDecided(blkDecided), .blkContinue(blkContinue),
    .busAddrOut(busAddrOut), .busAddrIn(busAddrIn), .busAddrOe(busAddrOe),
    .busDataOut(busDataOut), .busDataIn(busDataIn), .busDataOe(busDataOe),
    .busAsN(busAsN), .busDsN(busDsN), .busIackN(busIackN),
    .busCtrlOe(busCtrlOe), .busDtackN(busDtackN)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard: expected read words, compared on each rise of data-present
  logic [63:0] expQ[$];
  logic [63:0] expItem;
  logic        prevValid = 1'b0;

  always @(negedge clk) begin
    if (rstN && rspDataValid && !prevValid) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R4 unexpected read data: actual %h expected none", rspRdata);
      end else begin
        expItem = expQ.pop_front();
        check("R4", "scoreboard read word", rspRdata, expItem);
      end
    end
    prevValid <= rspDataValid;
  end

  task automatic startReq(input logic [AW-1:0] a, input logic [2*AW-1:0] d,
                          input logic [5:0] am, input logic wr);
    @(negedge clk);
    reqAddr  = a;
    reqWdata = d;
    reqAm    = am;
    reqWrite = wr;
    reqGo    = 1'b1;
    @(negedge clk);
    reqGo    = 1'b0;
  endtask

  task automatic waitStrobe(input string req);
    int n = 0;
    while (busDsN !== 2'b00 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(req, "strobe reached", 64'(busDsN), 64'd0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "busy after reset", 64'(rspBusy), 64'd0);
    check("R11", "AS after reset", 64'(busAsN), 64'd1);
    check("R11", "oe after reset", 64'({busAddrOe, busDataOe, busCtrlOe}), 64'd0);
    check("R11", "err after reset", 64'(rspErr), 64'd0);
    rstN = 1'b1;

    // ---- single-cycle write ----
    startReq(32'h00AB_CDEF, 64'h1111_2222_3333_4444, 6'h39, 1'b1);
    check("R1", "busy", 64'(rspBusy), 64'd1);
    check("R1", "go taken", 64'(rspGoTaken), 64'd1);
    check("R1", "addr oe", 64'(busAddrOe), 64'd1);
    check("R1", "addr lines", 64'(busAddrOut), 64'h00AB_CDEF);
    check("R1", "data oe", 64'(busDataOe), 64'd1);
    check("R1", "data lines", 64'(busDataOut), 64'h3333_4444);
    check("R1", "ctrl oe and iack", 64'({busCtrlOe, busIackN}), 64'd3);
    check("R2", "AS low", 64'(busAsN), 64'd0);
    check("R2", "DS high at start", 64'(busDsN), 64'd3);
    @(negedge clk);
    check("R1", "go taken one cycle", 64'(rspGoTaken), 64'd0);
    repeat (2) @(negedge clk);
    check("R2", "DS high at setup end", 64'(busDsN), 64'd3);
    @(negedge clk);
    check("R2", "DS low after setup", 64'(busDsN), 64'd0);
    busDtackN = 1'b0;
    @(negedge clk);
    check("R3", "idle after ack", 64'(rspBusy), 64'd0);
    check("R3", "groups released", 64'({busAddrOe, busDataOe, busCtrlOe}), 64'd0);
    check("R3", "AS released", 64'(busAsN), 64'd1);
    busDtackN = 1'b1;

    // ---- single-cycle read ----
    busDataIn = 32'hDEAD_BEEF;
    startReq(32'h0012_3456, 64'h0, 6'h39, 1'b0);
    check("R1", "read leaves data group input", 64'(busDataOe), 64'd0);
    check("R4", "present clear before ack", 64'(rspDataValid), 64'd0);
    waitStrobe("R4");
    expQ.push_back({32'h0, 32'hDEAD_BEEF});
    busDtackN = 1'b0;
    @(negedge clk);
    check("R4", "present after ack", 64'(rspDataValid), 64'd1);
    check("R4", "DS back high", 64'(busDsN), 64'd3);
    busDtackN = 1'b1;
    repeat (2) @(negedge clk);
    check("R5", "held until taken", 64'(rspBusy), 64'd1);
    dataTaken = 1'b1;
    @(negedge clk);
    dataTaken = 1'b0;
    check("R5", "idle after taken", 64'(rspBusy), 64'd0);
    check("R5", "present cleared", 64'(rspDataValid), 64'd0);

    // ---- unsupported modifier ----
    startReq(32'h0000_0100, 64'h5, 6'h3F, 1'b1);
    check("R9", "go taken on bad code", 64'(rspGoTaken), 64'd1);
    check("R9", "bad code error", 64'(rspErr), 64'd1);
    check("R9", "no busy", 64'(rspBusy), 64'd0);
    check("R9", "no AS", 64'(busAsN), 64'd1);
    repeat (5) @(negedge clk);
    check("R9", "still no cycle", 64'({rspBusy, busAddrOe, busDsN}), 64'd3);

    // ---- block write with one continuation ----
    startReq(32'h00F0_0000, 64'hAAAA_AAAA_0101_0101, 6'h3B, 1'b1);
    check("R9", "block code ok", 64'(rspErr), 64'd0);
    waitStrobe("R7");
    busDtackN = 1'b0;
    @(negedge clk);
    check("R7", "DS high on ack", 64'(busDsN), 64'd3);
    check("R7", "decision asked", 64'(rspBlkAsk), 64'd1);
    repeat (2) @(negedge clk);
    check("R7", "ask held", 64'(rspBlkAsk), 64'd1);
    blkDecided  = 1'b1;
    blkContinue = 1'b1;
    reqAddr  = 32'h00F0_0004;
    reqWdata = 64'hBBBB_BBBB_0202_0202;
    @(negedge clk);
    blkDecided = 1'b0;
    check("R8", "ask dropped", 64'(rspBlkAsk), 64'd0);
    check("R8", "new addr", 64'(busAddrOut), 64'h00F0_0004);
    check("R8", "new data", 64'(busDataOut), 64'h0202_0202);
    repeat (2) @(negedge clk);
    check("R8", "DS held while ack low", 64'(busDsN), 64'd3);
    busDtackN = 1'b1;
    @(negedge clk);
    check("R8", "DS high after release", 64'(busDsN), 64'd3);
    repeat (3) @(negedge clk);
    check("R8", "DS high at setup end", 64'(busDsN), 64'd3);
    @(negedge clk);
    check("R8", "DS low after setup", 64'(busDsN), 64'd0);
    busDtackN = 1'b0;
    @(negedge clk);
    check("R7", "second ask", 64'(rspBlkAsk), 64'd1);
    blkDecided  = 1'b1;
    blkContinue = 1'b0;
    @(negedge clk);
    blkDecided = 1'b0;
    busDtackN  = 1'b1;
    check("R7", "idle on stop", 64'(rspBusy), 64'd0);

    // ---- 64-bit block read ----
    busAddrIn = 32'hCAFE_F00D;
    busDataIn = 32'h1234_5678;
    startReq(32'h0044_0000, 64'h0, 6'h38, 1'b0);
    check("R9", "mblt code ok", 64'(rspErr), 64'd0);
    check("R6", "addr driven in address beat", 64'(busAddrOe), 64'd1);
    waitStrobe("R6");
    busDtackN = 1'b0;
    @(negedge clk);
    check("R6", "addr released after first ack", 64'(busAddrOe), 64'd0);
    check("R6", "no data on address beat", 64'(rspDataValid), 64'd0);
    busDtackN = 1'b1;
    waitStrobe("R6");
    check("R6", "addr released in data beat", 64'(busAddrOe), 64'd0);
    expQ.push_back({32'hCAFE_F00D, 32'h1234_5678});
    busDtackN = 1'b0;
    @(negedge clk);
    check("R6", "full word merged", rspRdata, {32'hCAFE_F00D, 32'h1234_5678});
    check("R7", "mblt ask", 64'(rspBlkAsk), 64'd1);
    busDtackN   = 1'b1;
    blkDecided  = 1'b1;
    blkContinue = 1'b0;
    @(negedge clk);
    blkDecided = 1'b0;
    check("R7", "mblt idle", 64'(rspBusy), 64'd0);

    // ---- watchdog ----
    startReq(32'h0000_0200, 64'h0, 6'h39, 1'b0);
    repeat (WDOG + 3) @(negedge clk);
    check("R10", "still waiting", 64'(rspBusy), 64'd1);
    @(negedge clk);
    check("R10", "ended by watchdog", 64'(rspBusy), 64'd0);
    check("R10", "timeout code", 64'(rspErr), 64'd2);
    check("R10", "lines released", 64'({busAddrOe, busDataOe, busCtrlOe, busAsN}), 64'd1);

    check("R4", "scoreboard drained", 64'(expQ.size()), 64'd0);
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule